// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a microcontroller between its running and sleeping modes. When the core executes a sleep instruction, the block picks the real low-power mode. The choice depends on the kind of instruction (stop or wait), the requested stop depth, the low-voltage-detect settings and whether the chip was already in low-power run. From the chosen mode it drives the regulator levels for the core and RAM domains, the core and RAM clock enables, one clock enable per peripheral and the debug clock enable. It watches a vector of wake sources and the low-voltage trip, and on a wake it brings the chip back to the running mode that was active before it slept.

The low-voltage detector works only under full regulation. Stop requests made while detection is armed for stop are therefore forced into the shallow full-regulation stop, whatever depth was requested. Per-peripheral gating bits are honoured only in the two low-power running and waiting modes. Every stop mode halts all peripheral clocks. The plain run and wait modes keep all of them running.

Top module: `lpm_ctrl`

## Requirements
- R1: An active-low `rst_n` forces the block into run mode (mode 0) at once, without waiting for a clock edge. While reset is held, all peripheral clock enables are 1, the core regulator is full, `lvd_rst_req` is 0 and `dbg_clk_en` follows `dbg_en`.
- R2: A stop request (`sleep_req`=1, `stop_sel`=1) made while `lvd_en` and `lvd_stop_en` are both 1 enters stop4 (mode 6), whatever `deep_lvl` holds. With only one of the two bits set, R3 applies.
- R3: Otherwise a stop request selects its mode from `deep_lvl`: 2 gives stop2 (mode 4), 3 gives stop3 (mode 5), and 0 or 1 gives stop4 (mode 6).
- R4: A wait request (`sleep_req`=1, `stop_sel`=0) enters wait (mode 2) from run and low-power wait (mode 3) from low-power run.
- R5: The mode is registered. It changes at the first rising clock edge that samples the request and holds steady between edges.
- R6: In any sleeping mode (2 to 6), a wake causes a return at the next edge to the running mode (run 0 or low-power run 1) that was active before entry. A wake is any set bit of `wake_src`, or a `lvd_trip` while `lvd_en`=1 and `lvd_rst_sel`=0.
- R7: In modes 4, 5 and 6 every bit of `periph_clk_en` is 0. In modes 0 and 2 every bit is 1.
- R8: In modes 1 and 3, `periph_clk_en` equals `gate_cfg` bit for bit, and follows it within the same cycle.
- R9: The regulator code is 00 full, 01 soft and 10 off. `reg_state` is full in modes 0, 2 and 6, soft in 1, 3 and 5, and off in 4. `ram_reg` equals `reg_state`, except in mode 4, where it is soft. `core_clk_en` and `ram_clk_en` are 1 only in modes 0 and 1.
- R10: `dbg_clk_en` equals `dbg_en` in every mode, the stop modes included.
- R11: A sleep request that arrives in the same cycle as a wake is dropped. The block stays in its running mode, and that cycle is handled as an ordinary running cycle.
- R12: A `lvd_trip` while `lvd_en`=1 and `lvd_rst_sel`=1 sets `lvd_rst_req` one cycle later and does not count as a wake.
- R13: In run with `lpr_en`=1 the block moves to low-power run, and in low-power run with `lpr_en`=0 it moves back to run, one edge later. A sleep request in the same cycle takes precedence over this move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle pulse: the core executed a sleep instruction |
| stop_sel | input | 1 | 1 = stop instruction, 0 = wait instruction |
| deep_lvl | input | 2 | Requested stop depth (2 = stop2, 3 = stop3, else stop4) |
| lpr_en | input | 1 | Low-power run enable |
| lvd_en | input | 1 | Low-voltage detect enable |
| lvd_stop_en | input | 1 | Keep low-voltage detect armed in stop |
| lvd_rst_sel | input | 1 | 1 = low-voltage trip requests reset, 0 = interrupt |
| lvd_trip | input | 1 | Low-voltage comparator trip |
| dbg_en | input | 1 | Debug enable |
| wake_src | input | NUM_WAKE | Interrupt wake sources |
| gate_cfg | input | GATE_REGS*GATE_REG_W | Per-peripheral gating bits of the two gating registers |
| mode | output | 3 | Current mode code (0 run, 1 lp run, 2 wait, 3 lp wait, 4 stop2, 5 stop3, 6 stop4) |
| reg_state | output | 2 | Core regulator level |
| ram_reg | output | 2 | RAM regulator level |
| core_clk_en | output | 1 | Core clock enable |
| ram_clk_en | output | 1 | RAM clock enable |
| periph_clk_en | output | GATE_REGS*GATE_REG_W | Per-peripheral clock enables |
| dbg_clk_en | output | 1 | Debug clock enable |
| lvd_rst_req | output | 1 | Low-voltage reset request to the reset controller |

## Verification
Two pairs of events can fall in the same cycle. A sleep request can arrive together with a wake, and a sleep request can arrive together with a change of `lpr_en` in a running mode. The bench drives both pairs on the same cycle, first in directed steps and then in a long seeded random phase with dense sleep and wake traffic. A behavioural model, written from the requirements, predicts the dropped request (R11) or the precedence of sleep (R13). Every output is compared with that model on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      M_RUN    = 3'd0,
      M_LPRUN  = 3'd1,
      M_WAIT   = 3'd2,
      M_LPWAIT = 3'd3,
      M_STOP2  = 3'd4,
      M_STOP3  = 3'd5,
      M_STOP4  = 3'd6
   } lpm_mode_e;

   typedef enum logic [1:0] {
      REG_FULL = 2'b00,
      REG_SOFT = 2'b01,
      REG_OFF  = 2'b10
   } reg_lvl_e;

   localparam logic [1:0] DEPTH_STOP2 = 2'd2;
   localparam logic [1:0] DEPTH_STOP3 = 2'd3;

   function automatic logic mode_awake(input lpm_mode_e m);
      return (m == M_RUN) || (m == M_LPRUN);
   endfunction

endpackage

// File: rtl/lpm_target.sv
module lpm_target
   import lpm_pkg::*;
(
   input  lpm_mode_e  cur_mode,
   input  logic       stop_sel,
   input  logic [1:0] deep_lvl,
   input  logic       lvd_en,
   input  logic       lvd_stop_en,
   output lpm_mode_e  target
);
   logic lvd_hold;

   assign lvd_hold = lvd_en & lvd_stop_en;

   always_comb begin
      if (!stop_sel) begin
         target = (cur_mode == M_LPRUN) ? M_LPWAIT : M_WAIT;
      end else if (lvd_hold) begin
         target = M_STOP4;
      end else begin
         unique case (deep_lvl)
            DEPTH_STOP2: target = M_STOP2;
            DEPTH_STOP3: target = M_STOP3;
            default:     target = M_STOP4;
         endcase
      end
   end
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
   parameter int NUM_WAKE = 8,
   parameter bit LVD_WAKE = 1'b1
) (
   input  logic [NUM_WAKE-1:0] wake_src,
   input  logic                lvd_en,
   input  logic                lvd_trip,
   input  logic                lvd_rst_sel,
   output logic                wake_any,
   output logic                lvd_rst_hit
);
   logic lvd_live;

   assign lvd_live    = lvd_en & lvd_trip;
   assign lvd_rst_hit = lvd_live & lvd_rst_sel;

   generate
      if (LVD_WAKE) begin : g_lvd_wake
         assign wake_any = (|wake_src) | (lvd_live & ~lvd_rst_sel);
      end else begin : g_src_only
         assign wake_any = |wake_src;
      end
   endgenerate
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sleep_req,
   input  logic      lpr_en,
   input  logic      wake_any,
   input  logic      lvd_rst_hit,
   input  lpm_mode_e target,
   output lpm_mode_e mode_q,
   output logic      lvd_rst_q
);
   lpm_mode_e mode_d;
   logic      ret_lp_q, ret_lp_d;

   always_comb begin
      mode_d   = mode_q;
      ret_lp_d = ret_lp_q;
      if (mode_awake(mode_q)) begin
         if (sleep_req && !wake_any) begin
            mode_d   = target;
            ret_lp_d = (mode_q == M_LPRUN);
         end else begin
            mode_d = lpr_en ? M_LPRUN : M_RUN;
         end
      end else if (wake_any) begin
         mode_d = ret_lp_q ? M_LPRUN : M_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= M_RUN;
         ret_lp_q  <= 1'b0;
         lvd_rst_q <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         ret_lp_q  <= ret_lp_d;
         lvd_rst_q <= lvd_rst_hit;
      end
   end
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
   import lpm_pkg::*;
#(
   parameter int NUM_PERIPH = 16
) (
   input  lpm_mode_e             mode,
   input  logic [NUM_PERIPH-1:0] gate_cfg,
   output reg_lvl_e              core_reg,
   output reg_lvl_e              ram_reg,
   output logic                  core_clk_en,
   output logic                  ram_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en
);
   logic all_on, use_gate;

   always_comb begin
      unique case (mode)
         M_LPRUN, M_LPWAIT, M_STOP3: core_reg = REG_SOFT;
         M_STOP2:                    core_reg = REG_OFF;
         default:                    core_reg = REG_FULL;
      endcase
      ram_reg     = (mode == M_STOP2) ? REG_SOFT : core_reg;
      core_clk_en = mode_awake(mode);
      ram_clk_en  = mode_awake(mode);
      all_on      = (mode == M_RUN) || (mode == M_WAIT);
      use_gate    = (mode == M_LPRUN) || (mode == M_LPWAIT);
   end

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
         assign periph_clk_en[i] = all_on | (use_gate & gate_cfg[i]);
      end
   endgenerate
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int NUM_WAKE   = 8,
   parameter int GATE_REG_W = 8,
   parameter int GATE_REGS  = 2,
   parameter bit LVD_WAKE   = 1'b1,
   localparam int NUM_PERIPH = GATE_REG_W * GATE_REGS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sleep_req,
   input  logic                  stop_sel,
   input  logic [1:0]            deep_lvl,
   input  logic                  lpr_en,
   input  logic                  lvd_en,
   input  logic                  lvd_stop_en,
   input  logic                  lvd_rst_sel,
   input  logic                  lvd_trip,
   input  logic                  dbg_en,
   input  logic [NUM_WAKE-1:0]   wake_src,
   input  logic [NUM_PERIPH-1:0] gate_cfg,
   output logic [2:0]            mode,
   output logic [1:0]            reg_state,
   output logic [1:0]            ram_reg,
   output logic                  core_clk_en,
   output logic                  ram_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  dbg_clk_en,
   output logic                  lvd_rst_req
);
   generate
      if (NUM_WAKE < 1) begin : g_bad_wake
         $error("lpm_ctrl: NUM_WAKE must be at least 1");
      end
      if (GATE_REG_W < 1 || GATE_REGS < 1) begin : g_bad_gate
         $error("lpm_ctrl: gating register shape must be non-empty");
      end
   endgenerate

   lpm_mode_e mode_q, target;
   reg_lvl_e  core_lvl, ram_lvl;
   logic      wake_any, lvd_rst_hit;

   lpm_wake #(.NUM_WAKE(NUM_WAKE), .LVD_WAKE(LVD_WAKE)) u_wake (
      .wake_src    (wake_src),
      .lvd_en      (lvd_en),
      .lvd_trip    (lvd_trip),
      .lvd_rst_sel (lvd_rst_sel),
      .wake_any    (wake_any),
      .lvd_rst_hit (lvd_rst_hit)
   );

   lpm_target u_target (
      .cur_mode    (mode_q),
      .stop_sel    (stop_sel),
      .deep_lvl    (deep_lvl),
      .lvd_en      (lvd_en),
      .lvd_stop_en (lvd_stop_en),
      .target      (target)
   );

   lpm_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .lpr_en      (lpr_en),
      .wake_any    (wake_any),
      .lvd_rst_hit (lvd_rst_hit),
      .target      (target),
      .mode_q      (mode_q),
      .lvd_rst_q   (lvd_rst_req)
   );

   lpm_gate_dec #(.NUM_PERIPH(NUM_PERIPH)) u_dec (
      .mode          (mode_q),
      .gate_cfg      (gate_cfg),
      .core_reg      (core_lvl),
      .ram_reg       (ram_lvl),
      .core_clk_en   (core_clk_en),
      .ram_clk_en    (ram_clk_en),
      .periph_clk_en (periph_clk_en)
   );

   assign mode       = mode_q;
   assign reg_state  = core_lvl;
   assign ram_reg    = ram_lvl;
   assign dbg_clk_en = dbg_en;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int NUM_WAKE   = 8,
   parameter int NUM_PERIPH = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sleep_req,
   input logic                  stop_sel,
   input logic [1:0]            deep_lvl,
   input logic                  lpr_en,
   input logic                  lvd_en,
   input logic                  lvd_stop_en,
   input logic                  lvd_rst_sel,
   input logic                  lvd_trip,
   input logic                  dbg_en,
   input logic [NUM_WAKE-1:0]   wake_src,
   input logic [NUM_PERIPH-1:0] gate_cfg,
   input logic [2:0]            mode,
   input logic [1:0]            reg_state,
   input logic [1:0]            ram_reg,
   input logic                  core_clk_en,
   input logic                  ram_clk_en,
   input logic [NUM_PERIPH-1:0] periph_clk_en,
   input logic                  dbg_clk_en,
   input logic                  lvd_rst_req
);
   logic awake, woke, go_stop;

   assign awake   = (mode == 3'd0) || (mode == 3'd1);
   assign woke    = (|wake_src) || (lvd_en && lvd_trip && !lvd_rst_sel);
   assign go_stop = awake && sleep_req && stop_sel && !woke;

   p_stop4_lvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go_stop && lvd_en && lvd_stop_en |=> mode == 3'd6);

   p_stop2_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go_stop && !(lvd_en && lvd_stop_en) && deep_lvl == 2'd2 |=> mode == 3'd4);

   p_wake_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !awake && woke |=> (mode == 3'd0 || mode == 3'd1));

   p_stop_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode >= 3'd4 |-> periph_clk_en == '0);

   p_lp_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1 || mode == 3'd3) |-> periph_clk_en == gate_cfg);

   p_stop2_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 3'd4 |-> reg_state == 2'b10 && ram_reg == 2'b01);

   p_clk_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en == awake && ram_clk_en == awake);

   p_dbg_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_clk_en == dbg_en);

   p_drop_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      awake && sleep_req && woke |=> (mode == 3'd0 || mode == 3'd1));

   p_lvd_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
      lvd_en && lvd_trip && lvd_rst_sel |=> lvd_rst_req);

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_WAKE(NUM_WAKE), .NUM_PERIPH(NUM_PERIPH)) u_chk (.*);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
   localparam int NW = 8;
   localparam int NP = 16;

   logic          clk = 1'b0;
   logic          rst_n, sleep_req, stop_sel, lpr_en, lvd_en, lvd_stop_en;
   logic          lvd_rst_sel, lvd_trip, dbg_en;
   logic [1:0]    deep_lvl;
   logic [NW-1:0] wake_src;
   logic [NP-1:0] gate_cfg;
   logic [2:0]    mode;
   logic [1:0]    reg_state, ram_reg;
   logic          core_clk_en, ram_clk_en, dbg_clk_en, lvd_rst_req;
   logic [NP-1:0] periph_clk_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int ms   = 0;
   int mret = 0;
   bit mlvd = 1'b0;

   always #2.5 clk = ~clk;

   lpm_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stop_sel(stop_sel),
      .deep_lvl(deep_lvl), .lpr_en(lpr_en), .lvd_en(lvd_en),
      .lvd_stop_en(lvd_stop_en), .lvd_rst_sel(lvd_rst_sel), .lvd_trip(lvd_trip),
      .dbg_en(dbg_en), .wake_src(wake_src), .gate_cfg(gate_cfg), .mode(mode),
      .reg_state(reg_state), .ram_reg(ram_reg), .core_clk_en(core_clk_en),
      .ram_clk_en(ram_clk_en), .periph_clk_en(periph_clk_en),
      .dbg_clk_en(dbg_clk_en), .lvd_rst_req(lvd_rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // one clock: compare all outputs against the model, then advance the model
   task automatic cyc();
      int nxt, nret, exp_reg, exp_ram;
      logic [NP-1:0] exp_per;
      bit wk, aw;
      if (!rst_n) begin ms = 0; mret = 0; mlvd = 1'b0; end
      #1;
      aw = (ms == 0) || (ms == 1);
      case (ms)
         1, 3, 5: exp_reg = 1;
         4:       exp_reg = 2;
         default: exp_reg = 0;
      endcase
      exp_ram = (ms == 4) ? 1 : exp_reg;
      if (ms == 0 || ms == 2)      exp_per = '1;
      else if (ms == 1 || ms == 3) exp_per = gate_cfg;
      else                         exp_per = '0;
      chk("R5 mode", 32'(mode), 32'(ms));
      chk("R9 core regulator", 32'(reg_state), 32'(exp_reg));
      chk("R9 ram regulator", 32'(ram_reg), 32'(exp_ram));
      chk("R9 core/ram clocks", {30'd0, core_clk_en, ram_clk_en}, {30'd0, aw, aw});
      chk("R7 R8 peripheral clocks", 32'(periph_clk_en), 32'(exp_per));
      chk("R10 debug clock", 32'(dbg_clk_en), 32'(dbg_en));
      chk("R12 lvd reset request", 32'(lvd_rst_req), 32'(mlvd));
      wk   = (|wake_src) || (lvd_en && lvd_trip && !lvd_rst_sel);
      nxt  = ms;
      nret = mret;
      if (aw) begin
         if (sleep_req && !wk) begin
            nret = ms;
            if (!stop_sel)                  nxt = (ms == 1) ? 3 : 2;
            else if (lvd_en && lvd_stop_en) nxt = 6;
            else if (deep_lvl == 2'd2)      nxt = 4;
            else if (deep_lvl == 2'd3)      nxt = 5;
            else                            nxt = 6;
         end else begin
            nxt = lpr_en ? 1 : 0;
         end
      end else if (wk) begin
         nxt = mret;
      end
      @(posedge clk);
      if (rst_n) begin
         ms   = nxt;
         mret = nret;
         mlvd = lvd_en && lvd_trip && lvd_rst_sel;
      end
      @(negedge clk);
   endtask

   task automatic expect_mode(input string req, input int exp);
      #1;
      chk(req, 32'(mode), 32'(exp));
   endtask

   task automatic do_sleep(input bit stop, input logic [1:0] d);
      sleep_req = 1'b1; stop_sel = stop; deep_lvl = d;
      cyc();
      sleep_req = 1'b0;
   endtask

   task automatic do_wake(input logic [NW-1:0] w);
      wake_src = w;
      cyc();
      wake_src = '0;
   endtask

   initial begin
      rst_n = 1'b0; sleep_req = 1'b0; stop_sel = 1'b0; deep_lvl = 2'd0;
      lpr_en = 1'b0; lvd_en = 1'b0; lvd_stop_en = 1'b0; lvd_rst_sel = 1'b0;
      lvd_trip = 1'b0; dbg_en = 1'b1; wake_src = '0; gate_cfg = 16'hA5C3;
      @(negedge clk);
      repeat (3) cyc();
      expect_mode("R1 reset mode", 0);
      chk("R1 all peripherals on", 32'(periph_clk_en), 32'hFFFF);
      rst_n = 1'b1;
      repeat (2) cyc();

      // R3 depth selection
      do_sleep(1'b1, 2'd2); expect_mode("R3 stop2", 4);
      repeat (2) cyc();
      do_wake(8'h04);       expect_mode("R6 back to run", 0);
      do_sleep(1'b1, 2'd3); expect_mode("R3 stop3", 5);
      repeat (4) cyc();     expect_mode("R3 stop3 held", 5);
      do_wake(8'h80);
      do_sleep(1'b1, 2'd1); expect_mode("R3 stop4 default", 6);
      do_wake(8'h01);

      // R2 forced shallow stop
      lvd_en = 1'b1; lvd_stop_en = 1'b1;
      do_sleep(1'b1, 2'd2); expect_mode("R2 forced stop4", 6);
      dbg_en = 1'b0; cyc(); dbg_en = 1'b1; cyc();
      lvd_trip = 1'b1; cyc(); lvd_trip = 1'b0;
      expect_mode("R6 lvd interrupt wake", 0);
      lvd_stop_en = 1'b0;
      do_sleep(1'b1, 2'd3); expect_mode("R2 single bit not enough", 5);
      do_wake(8'h10);

      // R4 wait from run
      do_sleep(1'b0, 2'd2); expect_mode("R4 wait", 2);
      chk("R7 wait keeps clocks", 32'(periph_clk_en), 32'hFFFF);
      do_wake(8'h02);

      // R13 / R8 low-power run
      lpr_en = 1'b1; cyc(); expect_mode("R13 enter lp run", 1);
      gate_cfg = 16'h0F0F; cyc(); gate_cfg = 16'h8001; cyc();
      do_sleep(1'b0, 2'd0); expect_mode("R4 lp wait", 3);
      gate_cfg = 16'h3C3C; cyc();
      do_wake(8'h08);       expect_mode("R6 back to lp run", 1);
      do_sleep(1'b1, 2'd2); expect_mode("R3 stop2 from lp run", 4);
      do_wake(8'h20);       expect_mode("R6 stop2 to lp run", 1);
      lpr_en = 1'b0; cyc(); expect_mode("R13 leave lp run", 0);

      // R11 sleep and wake in one cycle
      wake_src = 8'h40; do_sleep(1'b1, 2'd3); wake_src = '0;
      expect_mode("R11 request dropped", 0);
      // R13 sleep wins over lp run entry
      lpr_en = 1'b1; do_sleep(1'b1, 2'd0); expect_mode("R13 sleep first", 6);
      do_wake(8'h01); expect_mode("R13 wake to run", 0);
      cyc();          expect_mode("R13 then lp run", 1);
      lpr_en = 1'b0; cyc();

      // R12 lvd reset path is not a wake
      lvd_stop_en = 1'b1;
      do_sleep(1'b1, 2'd0);
      lvd_rst_sel = 1'b1; lvd_trip = 1'b1; cyc();
      expect_mode("R12 no wake on reset trip", 6);
      chk("R12 request raised", 32'(lvd_rst_req), 32'd1);
      lvd_trip = 1'b0; lvd_rst_sel = 1'b0; cyc();

      // R1 asynchronous reset out of a stop mode
      lvd_en = 1'b0; lvd_stop_en = 1'b0;
      do_sleep(1'b1, 2'd2);
      #1 rst_n = 1'b0;
      #0.5 chk("R1 async reset", 32'(mode), 32'd0);
      @(negedge clk);
      cyc(); rst_n = 1'b1; cyc();

      // seeded random traffic
      void'($urandom(32'd17));
      for (int i = 0; i < 3000; i++) begin
         sleep_req   = ($urandom % 4) == 0;
         stop_sel    = $urandom % 2;
         deep_lvl    = 2'($urandom % 4);
         lpr_en      = ($urandom % 8) != 0 ? lpr_en : ~lpr_en;
         lvd_en      = $urandom % 2;
         lvd_stop_en = $urandom % 2;
         lvd_rst_sel = $urandom % 2;
         lvd_trip    = ($urandom % 10) == 0;
         dbg_en      = $urandom % 2;
         wake_src    = (($urandom % 5) == 0) ? NW'(1 << ($urandom % NW)) : '0;
         gate_cfg    = NP'($urandom);
         cyc();
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule